// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block generates the serial clock of an I2C master from the system clock. A 7-bit divider setting `tpr` selects the bit rate. A prescaler turns the setting into a base tick that lasts 2 × (1 + tpr) system clocks. Each SCL period is ten such ticks: six with SCL low, followed by four with SCL high. One SCL period therefore lasts 20 × (1 + tpr) system clocks. With an 80 MHz system clock, a setting of 39 gives 100 kbps (800 clocks per period) and a setting of 9 gives 400 kbps (200 clocks per period).

Besides the SCL level, the block drives four single-cycle strobes for a bit engine. They mark the falling edge, the rising edge, the middle of the low phase (where SDA may change) and the middle of the high phase (where SDA is sampled). While `enable` is low, SCL is released high and every counter is held cleared. A new divider setting takes effect only at the start of an SCL period, so no period is ever a mix of two rates.

Top module: `scl_clock_gen`

## Requirements
- R1: While enabled, consecutive falling-edge strobes are exactly 20 × (1 + tpr) system clocks apart.
- R2: Within each period, SCL is low for exactly 12 × (1 + tpr) clocks, starting in the cycle that carries the falling-edge strobe.
- R3: Within each period, SCL is high for exactly 8 × (1 + tpr) clocks, from the rising-edge strobe up to the next falling-edge strobe.
- R4: `tpr` is captured only when a period starts: at the first enabled clock edge, and at each later falling edge. A change in the middle of a period alters only the next period.
- R5: While `enable` is low, `scl_o` is 1 and all strobes are 0; this state is reached one clock after `enable` is sampled low. The first clock edge that samples `enable` high drives `scl_o` to 0 and raises `scl_fall_stb`.
- R6: Each strobe is one cycle wide, at most one strobe is high in any cycle, `scl_fall_stb` coincides with the first low cycle, and `scl_rise_stb` coincides with the first high cycle.
- R7: `low_mid_stb` occurs 6 × (1 + tpr) clocks after the falling-edge strobe, and `high_mid_stb` occurs 4 × (1 + tpr) clocks after the rising-edge strobe.
- R8: The divider limits work: tpr = 0 gives a 20-clock period and tpr = 127 gives a 2560-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL generator; when low, SCL is released high |
| tpr | input | 7 | Divider setting; base tick = 2 × (1 + tpr) clocks |
| scl_o | output | 1 | SCL drive level (1 = released) |
| scl_fall_stb | output | 1 | One-cycle strobe in the first cycle of SCL low |
| scl_rise_stb | output | 1 | One-cycle strobe in the first cycle of SCL high |
| high_mid_stb | output | 1 | One-cycle strobe at the middle of the high phase (sampling point) |
| low_mid_stb | output | 1 | One-cycle strobe at the middle of the low phase |

## Verification
The main function is driven with five divider settings: the two standard rates (39 and 9), the limits 0 and 127, and a small odd value. For each setting the bench measures the period, the low and high lengths and both mid-phase strobe offsets. A wrong multiplier, phase split or off-by-one in the prescaler therefore shows up as a length mismatch at a specific setting, and the tpr = 0 case exposes any limit that assumes more than one count per tick. A setting change in the middle of a low phase separates capture at the period boundary from immediate use. Disabling in the middle of a period, together with the enable latency check, separates a clean release from one that leaks strobes or restarts late.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Phase of the generated clock within one period
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    // Event strobes handed to the bit engine
    typedef struct packed {
        logic fall;
        logic rise;
        logic high_mid;
        logic low_mid;
    } scl_strb_t;

endpackage

// File: rtl/scl_tpr_hold.sv
module scl_tpr_hold #(
    parameter int TPR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TPR_W-1:0] tpr_in,
    output logic [TPR_W-1:0] tpr_act
);

    typedef struct packed {
        logic [TPR_W-1:0] val;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.val = tpr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign tpr_act = hold_q.val;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int TPR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [TPR_W-1:0] tpr_act,
    output logic             tick
);

    // Base unit spans 2*(1+tpr) clocks; counter runs 0 .. 2*tpr+1
    localparam int CNT_W = TPR_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [CNT_W-1:0] last_cnt;
    logic             tick_c;

    // 2*tpr + 1 as a shift plus one
    assign last_cnt = {tpr_act, 1'b1};

    always_comb begin
        pre_d  = pre_q;
        tick_c = count_en && (pre_q.cnt == last_cnt);
        if (!count_en) begin
            pre_d.cnt = '0;
        end else if (tick_c) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign tick = tick_c;

    // R1: the count never runs past the end of the current base unit
    p_pre_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (pre_q.cnt <= last_cnt));

    // R5: a stopped prescaler sits at zero
    p_pre_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (pre_q.cnt == '0));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int LOW_UNITS  = 6,
    parameter int HIGH_UNITS = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      tick,
    output logic      running,
    output logic      period_end,
    output logic      scl,
    output scl_strb_t strb
);

    localparam int TOTAL_UNITS = LOW_UNITS + HIGH_UNITS;
    localparam int UNIT_W      = $clog2(TOTAL_UNITS);
    localparam int LAST_UNIT   = TOTAL_UNITS - 1;
    localparam int HMID_UNIT   = LOW_UNITS + HIGH_UNITS / 2;
    localparam int LMID_UNIT   = LOW_UNITS / 2;

    typedef struct packed {
        logic              run;
        logic [UNIT_W-1:0] unit;
        scl_phase_e        phase;
        scl_strb_t         strb;
    } seq_t;

    seq_t seq_d, seq_q;
    logic              start_c;
    logic              wrap_c;
    logic [UNIT_W-1:0] unit_nx;

    always_comb begin
        start_c = enable && !seq_q.run;
        wrap_c  = seq_q.run && tick && (seq_q.unit == UNIT_W'(LAST_UNIT));
        unit_nx = wrap_c ? '0 : (seq_q.unit + UNIT_W'(1));

        seq_d      = seq_q;
        seq_d.run  = enable;
        seq_d.strb = '0;

        if (!enable) begin
            seq_d.unit  = '0;
            seq_d.phase = PH_HIGH;
        end else if (start_c) begin
            seq_d.unit      = '0;
            seq_d.phase     = PH_LOW;
            seq_d.strb.fall = 1'b1;
        end else if (tick) begin
            seq_d.unit          = unit_nx;
            seq_d.phase         = (unit_nx >= UNIT_W'(LOW_UNITS)) ? PH_HIGH : PH_LOW;
            seq_d.strb.fall     = wrap_c;
            seq_d.strb.rise     = (unit_nx == UNIT_W'(LOW_UNITS));
            seq_d.strb.high_mid = (unit_nx == UNIT_W'(HMID_UNIT));
            seq_d.strb.low_mid  = (unit_nx == UNIT_W'(LMID_UNIT));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_HIGH;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign running    = seq_q.run;
    assign period_end = wrap_c;
    assign scl        = (seq_q.phase == PH_HIGH);
    assign strb       = seq_q.strb;

    // R5: disabled generator releases the line and is silent
    p_released_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl && (strb == '0)));

    // R6: never two events in one cycle
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    // R6: falling strobe marks the first low cycle
    p_fall_marks_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strb.fall |-> (!scl && $past(scl)));

    // R6: rising strobe marks the first high cycle
    p_rise_marks_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strb.rise |-> (scl && !$past(scl)));

    // R1: unit index stays inside one period
    p_unit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.unit <= UNIT_W'(LAST_UNIT));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int TPR_W      = 7,
    parameter int LOW_UNITS  = 6,
    parameter int HIGH_UNITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [TPR_W-1:0] tpr,
    output logic             scl_o,
    output logic             scl_fall_stb,
    output logic             scl_rise_stb,
    output logic             high_mid_stb,
    output logic             low_mid_stb
);

    logic             run_q;
    logic             period_end;
    logic             tick;
    logic             load_tpr;
    logic [TPR_W-1:0] tpr_act;
    scl_strb_t        strb;

    // Capture a new setting while idle, on the start edge, or at a period boundary
    assign load_tpr = !run_q || period_end;

    scl_tpr_hold #(
        .TPR_W (TPR_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_tpr),
        .tpr_in  (tpr),
        .tpr_act (tpr_act)
    );

    scl_prescaler #(
        .TPR_W (TPR_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (enable && run_q),
        .tpr_act  (tpr_act),
        .tick     (tick)
    );

    scl_phase_seq #(
        .LOW_UNITS  (LOW_UNITS),
        .HIGH_UNITS (HIGH_UNITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .running    (run_q),
        .period_end (period_end),
        .scl        (scl_o),
        .strb       (strb)
    );

    assign scl_fall_stb = strb.fall;
    assign scl_rise_stb = strb.rise;
    assign high_mid_stb = strb.high_mid;
    assign low_mid_stb  = strb.low_mid;

    // R4: the active setting moves only together with a period start
    p_tpr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !scl_fall_stb) |-> $stable(tpr_act));

    // R7: the sampling strobe only appears while the line is high
    p_hmid_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        high_mid_stb |-> scl_o);

    // R7: the low-phase mid strobe only appears while the line is low
    p_lmid_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_mid_stb |-> !scl_o);

endmodule

// File: tb/scl_clock_gen_tb_top.sv
`timescale 1ns/1ps
module scl_clock_gen_tb_top;

    logic       clk;
    logic       rst_n;
    logic       enable;
    logic [6:0] tpr;
    logic       scl_o;
    logic       fall_stb;
    logic       rise_stb;
    logic       hmid_stb;
    logic       lmid_stb;

    int checks = 0;
    int errors = 0;

    localparam int VEC_N = 5;
    localparam logic [6:0] V_TPR [VEC_N] = '{7'd39, 7'd9, 7'd0, 7'd127, 7'd2};
    localparam int         V_PER [VEC_N] = '{800, 200, 20, 2560, 60};

    scl_clock_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .tpr          (tpr),
        .scl_o        (scl_o),
        .scl_fall_stb (fall_stb),
        .scl_rise_stb (rise_stb),
        .high_mid_stb (hmid_stb),
        .low_mid_stb  (lmid_stb)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge where the falling strobe is high; walks to the next one
    task automatic measure(input int chg_at, input logic [6:0] chg_v,
                           output int per, output int rise_at, output int hmid_at,
                           output int lmid_at, output int lowcnt, output int edge_bad);
        int n;
        n = 0; per = -1; rise_at = -1; hmid_at = -1; lmid_at = -1; edge_bad = 0;
        lowcnt = (scl_o == 1'b0) ? 1 : 0;
        while (per < 0 && n < 6000) begin
            @(negedge clk);
            n++;
            if (n == chg_at) tpr = chg_v;
            if ($countones({fall_stb, rise_stb, hmid_stb, lmid_stb}) > 1) edge_bad++;
            if (rise_stb) begin
                rise_at = n;
                if (!scl_o) edge_bad++;
            end
            if (hmid_stb) hmid_at = n;
            if (lmid_stb) lmid_at = n;
            if (fall_stb) begin
                per = n;
                if (scl_o) edge_bad++;
            end else if (!scl_o) begin
                lowcnt++;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per, ra, ha, la, lc, eb, k, quiet;
        rst_n = 1'b0; enable = 1'b0; tpr = 7'd0;
        repeat (3) @(negedge clk);
        // Reset state
        check(scl_o == 1'b1, "R5 reset scl", int'(scl_o), 1);
        check({fall_stb, rise_stb, hmid_stb, lmid_stb} == 4'b0, "R5 reset strobes",
              int'({fall_stb, rise_stb, hmid_stb, lmid_stb}), 0);
        rst_n = 1'b1;

        // Disabled: line stays released, nothing strobes
        quiet = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!scl_o || fall_stb || rise_stb || hmid_stb || lmid_stb) quiet++;
        end
        check(quiet == 0, "R5 idle quiet", quiet, 0);

        // Vector table walk
        for (int i = 0; i < VEC_N; i++) begin
            @(negedge clk);
            enable = 1'b0;
            tpr    = V_TPR[i];
            repeat (3) @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            check(fall_stb && !scl_o, "R5 start latency", int'(fall_stb), 1);
            k = V_PER[i] / 20;
            measure(0, 7'd0, per, ra, ha, la, lc, eb);
            check(per == V_PER[i], (V_TPR[i] == 0 || V_TPR[i] == 127) ? "R8 period" : "R1 period",
                  per, V_PER[i]);
            check(lc == 12 * k, "R2 low length", lc, 12 * k);
            check(per - ra == 8 * k, "R3 high length", per - ra, 8 * k);
            check(ha - ra == 4 * k, "R7 high mid", ha - ra, 4 * k);
            check(la == 6 * k, "R7 low mid", la, 6 * k);
            check(eb == 0, "R6 strobe shape", eb, 0);
            measure(0, 7'd0, per, ra, ha, la, lc, eb);
            check(per == V_PER[i], "R1 second period", per, V_PER[i]);
        end

        // Setting change in the middle of a low phase
        @(negedge clk);
        enable = 1'b0;
        tpr    = 7'd1;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        measure(5, 7'd3, per, ra, ha, la, lc, eb);
        check(per == 40, "R4 current period kept", per, 40);
        measure(0, 7'd3, per, ra, ha, la, lc, eb);
        check(per == 80, "R4 next period new rate", per, 80);
        check(lc == 48, "R4 next low length", lc, 48);

        // Disable in the middle of a low phase
        @(negedge clk);
        enable = 1'b0;
        tpr    = 7'd2;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        check(scl_o == 1'b0, "R2 low before disable", int'(scl_o), 0);
        enable = 1'b0;
        @(negedge clk);
        check(scl_o == 1'b1, "R5 release after disable", int'(scl_o), 1);
        quiet = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!scl_o || fall_stb || rise_stb || hmid_stb || lmid_stb) quiet++;
        end
        check(quiet == 0, "R5 silent after disable", quiet, 0);

        // Re-enable restarts a full period from the falling edge
        enable = 1'b1;
        @(negedge clk);
        check(fall_stb && !scl_o, "R5 restart", int'(fall_stb), 1);
        measure(0, 7'd2, per, ra, ha, la, lc, eb);
        check(per == 60, "R1 restart period", per, 60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule